// File: doc/BRIEF.md
# Flash Page Program-Verify Sequencer

This block programs one page of flash cells by alternating write pulses with verify reads until every cell meant to hold 0 reads back as 0. Before a run, the host fills an internal page buffer one byte at a time through a valid/ready write port. A single-cycle start pulse then launches the run. The block tracks, per bit, which cells still need a pulse. The main pulse in early loops is short and becomes long once the loop count passes a threshold. Cells that first read back as 0 during an early loop get one extra short top-up pulse in that same loop.

The flash side uses a byte-serial array interface. Before each pulse, the sequencer presents a pulse mask for every byte address, where bit value 1 means "pulse this cell". It then holds the pulse enable for an exact number of microsecond ticks. After that it reads back every byte. The run ends with done when nothing is left to program. It ends with fail when the loop limit is used up, or when a cell that should stay 1 reads back as 0. The number of loops run stays on an output until the next start.

Back-pressure on the write port is simple. A byte is taken on any rising clock edge where both valid and ready are high. Ready is high exactly while the sequencer is idle, so the page cannot change during a run. A source that holds valid while the block is busy simply waits; no byte is dropped or taken twice.

Top module: `fpv_seq`

## Requirements
- R1: A page byte is stored only on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is high exactly when `busy` is low, so writes offered during a run have no effect on that run or on later runs.
- R2: A `start` pulse while idle clears `done` and `fail`, resets the loop count to 0 and raises `busy` on the next cycle. A `start` pulse while busy is ignored.
- R3: Each loop first presents a pulse mask for byte addresses 0 to PAGE_BYTES-1, one per cycle with `fl_latch` high; mask bit 1 means the cell is pulsed. It then applies one pulse on `fl_pulse`. It then reads every byte with `fl_rd`; `fl_rdata` is taken in the cycle after `fl_rd`.
- R4: The main pulse of loop n covers exactly EARLY_TICKS (30) `us_tick` cycles when n is at most EARLY_LOOPS (6), and exactly LATE_TICKS (200) ticks otherwise.
- R5: In a loop n no greater than EARLY_LOOPS, cells whose read-back changes from 1 to 0 in that loop's verify get one top-up pulse of exactly TOPUP_TICKS (10) ticks after the verify pass. This pulse is issued only if at least one such cell exists. Loops above EARLY_LOOPS have no top-up pulse.
- R6: The set of cells pulsed in the next loop is every target-0 cell that read back as 1 in the latest verify. A cell that had already read 0 and later reads 1 is pulsed again.
- R7: A cell whose target bit is 1 is never pulsed. If such a cell reads back as 0, the run ends with `fail` right after that verify pass, with no top-up pulse.
- R8: When every target-0 cell reads back as 0, the run ends with `done`, and `loop_count` equals the number of loops run. An all-ones page ends with `done`, `loop_count` 0 and no pulse.
- R9: If target-0 cells still read 1 after MAX_LOOPS loops, the run ends with `fail` and `loop_count` equals MAX_LOOPS. No further pulse is issued.
- R10: After reset: `busy`, `done`, `fail`, `fl_pulse`, `fl_latch` and `fl_rd` are low, `wr_ready` is high, and `loop_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a programming run (used only while idle) |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| wr_valid | input | 1 | Page byte offered |
| wr_ready | output | 1 | Page byte accepted when high with wr_valid |
| wr_addr | input | $clog2(PAGE_BYTES) | Page byte address |
| wr_data | input | 8 | Target byte (bit 0 = cell to program) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed successfully |
| fail | output | 1 | Last run ended in failure |
| loop_count | output | $clog2(MAX_LOOPS+1) | Loops used by the current or last run |
| fl_latch | output | 1 | Pulse mask byte valid on fl_addr/fl_wdata |
| fl_addr | output | $clog2(PAGE_BYTES) | Array byte address for mask load and verify |
| fl_wdata | output | 8 | Pulse mask byte, 1 = pulse cell |
| fl_pulse | output | 1 | Write pulse enable |
| fl_rd | output | 1 | Verify read strobe |
| fl_rdata | input | 8 | Read-back byte, valid the cycle after fl_rd |

## Verification
The bench builds the block with PAGE_BYTES = 4 and MAX_LOOPS = 10, and keeps the default tick widths and EARLY_LOOPS = 6. With only 32 cells, it can give every cell its own pulse count to program and check each cell's received pulses against an arithmetic prediction. A limit of 10 loops lets both the short and long main pulses, and the loop-limit failure, happen within a few thousand cycles. The ticks arrive every second cycle, so pulse widths are measured in ticks rather than cycles.

// File: rtl/fpv_pkg.sv
package fpv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_LOAD, ST_ARM, ST_WAIT, ST_RDREQ, ST_RDCAP
  } seq_state_t;

  typedef enum logic {
    PK_MAIN, PK_TOPUP
  } pulse_kind_t;
endpackage

// File: rtl/fpv_pulse_timer.sv
module fpv_pulse_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          go,
  input  logic [CW-1:0] width,
  output logic          active
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] wid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
      wid_q  <= '0;
    end else if (go && !active) begin
      active <= 1'b1;
      cnt_q  <= '0;
      wid_q  <= width;
    end else if (active && tick) begin
      if (cnt_q == wid_q - CW'(1)) begin
        active <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R4/R5: the tick count never passes the latched width
  a_r4_tick_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q < wid_q));
endmodule

// File: rtl/fpv_mask_bank.sv
module fpv_mask_bank #(
  parameter int PAGE_BYTES = 128,
  parameter int AW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          init,
  input  logic [AW-1:0] sel,
  input  logic          upd_en,
  input  logic [7:0]    rdata,
  input  logic          early,
  input  logic          active,
  output logic          tgt_all_ones,
  output logic [7:0]    rep_byte,
  output logic [7:0]    top_byte,
  output logic          upd_rep_nz,
  output logic          upd_top_nz,
  output logic          upd_err
);
  logic [7:0] tgt_m [PAGE_BYTES];
  logic [7:0] rep_m [PAGE_BYTES];
  logic [7:0] top_m [PAGE_BYTES];
  logic [7:0] tgt_b, new_rep, new_top;

  assign tgt_b    = tgt_m[sel];
  assign rep_byte = rep_m[sel];
  assign top_byte = top_m[sel];
  assign new_rep  = ~tgt_b & rdata;
  assign new_top  = early ? (rep_m[sel] & ~rdata) : 8'h00;
  assign upd_rep_nz = |new_rep;
  assign upd_top_nz = |new_top;
  assign upd_err    = |(tgt_b & ~rdata);

  always_comb begin
    tgt_all_ones = 1'b1;
    for (int i = 0; i < PAGE_BYTES; i++) tgt_all_ones = tgt_all_ones & (&tgt_m[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        tgt_m[i] <= 8'hFF;
        rep_m[i] <= 8'h00;
        top_m[i] <= 8'h00;
      end
    end else begin
      if (wr_en) tgt_m[wr_addr] <= wr_data;
      if (init) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
          rep_m[i] <= ~tgt_m[i];
          top_m[i] <= 8'h00;
        end
      end else if (upd_en) begin
        rep_m[sel] <= new_rep;
        top_m[sel] <= new_top;
      end
    end
  end

  // R7: pulse masks never cover a cell whose target is 1 during a run
  a_r7_masks_within_target: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (((rep_m[sel] | top_m[sel]) & tgt_m[sel]) == 8'h00));
endmodule

// File: rtl/fpv_seq.sv
module fpv_seq #(
  parameter int PAGE_BYTES  = 128,
  parameter int MAX_LOOPS   = 1000,
  parameter int EARLY_LOOPS = 6,
  parameter int EARLY_TICKS = 30,
  parameter int LATE_TICKS  = 200,
  parameter int TOPUP_TICKS = 10,
  localparam int AW   = $clog2(PAGE_BYTES),
  localparam int LW   = $clog2(MAX_LOOPS + 1),
  localparam int MAXT = (LATE_TICKS > EARLY_TICKS)
                        ? ((LATE_TICKS > TOPUP_TICKS) ? LATE_TICKS : TOPUP_TICKS)
                        : ((EARLY_TICKS > TOPUP_TICKS) ? EARLY_TICKS : TOPUP_TICKS),
  localparam int TW   = $clog2(MAXT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          us_tick,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [LW-1:0] loop_count,
  output logic          fl_latch,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  output logic          fl_pulse,
  output logic          fl_rd,
  input  logic [7:0]    fl_rdata
);
  import fpv_pkg::*;

  seq_state_t    state_q;
  pulse_kind_t   kind_q;
  logic [AW-1:0] idx_q;
  logic [LW-1:0] loop_q;
  logic          rep_nz_q, acc_rep_q, acc_top_q, acc_err_q;
  logic          done_q, fail_q;
  logic          early, last, init, tmr_go, tmr_active;
  logic          all_ones, rep_nz_b, top_nz_b, err_b;
  logic [7:0]    rep_byte, top_byte;
  logic [TW-1:0] pw;

  assign busy       = (state_q != ST_IDLE);
  assign wr_ready   = !busy;
  assign done       = done_q;
  assign fail       = fail_q;
  assign loop_count = loop_q;
  assign early      = (loop_q <= LW'(EARLY_LOOPS));
  assign last       = (idx_q == AW'(PAGE_BYTES - 1));
  assign init       = (state_q == ST_IDLE) && start;
  assign tmr_go     = (state_q == ST_ARM);
  assign fl_latch   = (state_q == ST_LOAD);
  assign fl_rd      = (state_q == ST_RDREQ);
  assign fl_addr    = idx_q;
  assign fl_wdata   = (kind_q == PK_TOPUP) ? top_byte : rep_byte;
  assign fl_pulse   = tmr_active;
  assign pw = (kind_q == PK_TOPUP) ? TW'(TOPUP_TICKS)
            : (early ? TW'(EARLY_TICKS) : TW'(LATE_TICKS));

  fpv_mask_bank #(.PAGE_BYTES(PAGE_BYTES), .AW(AW)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_valid && wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .init(init), .sel(idx_q), .upd_en(state_q == ST_RDCAP), .rdata(fl_rdata),
    .early(early), .active(busy), .tgt_all_ones(all_ones),
    .rep_byte(rep_byte), .top_byte(top_byte),
    .upd_rep_nz(rep_nz_b), .upd_top_nz(top_nz_b), .upd_err(err_b)
  );

  fpv_pulse_timer #(.CW(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .tick(us_tick), .go(tmr_go), .width(pw),
    .active(tmr_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      kind_q    <= PK_MAIN;
      idx_q     <= '0;
      loop_q    <= '0;
      rep_nz_q  <= 1'b0;
      acc_rep_q <= 1'b0;
      acc_top_q <= 1'b0;
      acc_err_q <= 1'b0;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          done_q   <= 1'b0;
          fail_q   <= 1'b0;
          loop_q   <= '0;
          rep_nz_q <= !all_ones;
          state_q  <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!rep_nz_q) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (loop_q == LW'(MAX_LOOPS)) begin
            fail_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            loop_q  <= loop_q + LW'(1);
            kind_q  <= PK_MAIN;
            idx_q   <= '0;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (last) begin
            idx_q   <= '0;
            state_q <= ST_ARM;
          end else begin
            idx_q <= idx_q + AW'(1);
          end
        end
        ST_ARM: state_q <= ST_WAIT;
        ST_WAIT: if (!tmr_active) begin
          if (kind_q == PK_MAIN) begin
            acc_rep_q <= 1'b0;
            acc_top_q <= 1'b0;
            acc_err_q <= 1'b0;
            idx_q     <= '0;
            state_q   <= ST_RDREQ;
          end else begin
            state_q <= ST_CHECK;
          end
        end
        ST_RDREQ: state_q <= ST_RDCAP;
        ST_RDCAP: begin
          acc_rep_q <= acc_rep_q | rep_nz_b;
          acc_top_q <= acc_top_q | top_nz_b;
          acc_err_q <= acc_err_q | err_b;
          if (last) begin
            rep_nz_q <= acc_rep_q | rep_nz_b;
            idx_q    <= '0;
            if (acc_err_q || err_b) begin
              fail_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (acc_top_q || top_nz_b) begin
              kind_q  <= PK_TOPUP;
              state_q <= ST_LOAD;
            end else begin
              state_q <= ST_CHECK;
            end
          end else begin
            idx_q   <= idx_q + AW'(1);
            state_q <= ST_RDREQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: a run only begins from a start request
  a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R3: mask loading, pulsing and reading never overlap
  a_r3_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_pulse && (fl_latch || fl_rd)));
  // R9: the loop count never passes its limit
  a_r9_loop_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    loop_count <= LW'(MAX_LOOPS));
  // R8: the two end states are exclusive
  a_r8_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  // R7: no pulse outside a run
  a_r7_pulse_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    fl_pulse |-> busy);
endmodule

// File: tb/fpv_seq_tb.sv
module fpv_seq_tb_top;
  localparam int PB = 4;
  localparam int ML = 10;
  localparam int EL = 6;
  localparam int NB = PB * 8;
  localparam int AW = $clog2(PB);
  localparam int LW = $clog2(ML + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, us_tick = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic busy, done, fail, fl_latch, fl_pulse, fl_rd;
  logic [LW-1:0] loop_count;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata;
  logic [7:0] fl_rdata = 8'hFF;

  int tests = 0, fails = 0;
  int need [NB];
  int pulses [NB];
  bit latched [NB];
  logic [7:0] page [PB];
  int stuck_bit = -1, flaky_bit = -1, flaky_vc = 0;
  int h10 = 0, h30 = 0, h200 = 0, hoth = 0, cur_ticks = 0;
  logic pulse_prev = 1'b0;

  always #5 clk = ~clk;

  fpv_seq #(.PAGE_BYTES(PB), .MAX_LOOPS(ML), .EARLY_LOOPS(EL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .us_tick(us_tick),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .fail(fail), .loop_count(loop_count),
    .fl_latch(fl_latch), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_pulse(fl_pulse), .fl_rd(fl_rd), .fl_rdata(fl_rdata)
  );

  initial forever begin
    @(posedge clk);
    #1 us_tick = ~us_tick;
  end

  // flash array model: each cell flips to 0 after need[] pulses
  always @(negedge clk) begin
    if (fl_latch) for (int k = 0; k < 8; k++) latched[int'(fl_addr) * 8 + k] = fl_wdata[k];
    if (fl_rd) begin
      for (int k = 0; k < 8; k++) begin
        int b;
        b = int'(fl_addr) * 8 + k;
        if (b == stuck_bit) fl_rdata[k] = 1'b0;
        else if (pulses[b] >= need[b]) begin
          if (b == flaky_bit) begin
            flaky_vc++;
            fl_rdata[k] = (flaky_vc == 2);
          end else fl_rdata[k] = 1'b0;
        end else fl_rdata[k] = 1'b1;
      end
    end
    if (fl_pulse && us_tick) cur_ticks++;
    if (pulse_prev && !fl_pulse) begin
      if (cur_ticks == 10) h10++;
      else if (cur_ticks == 30) h30++;
      else if (cur_ticks == 200) h200++;
      else hoth++;
      for (int b = 0; b < NB; b++) if (latched[b]) pulses[b]++;
      cur_ticks = 0;
    end
    pulse_prev = fl_pulse;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit t0(input int b);
    return !page[b / 8][b % 8];
  endfunction

  task automatic model_clear();
    for (int b = 0; b < NB; b++) begin
      pulses[b] = 0;
      latched[b] = 1'b0;
    end
    flaky_vc = 0; h10 = 0; h30 = 0; h200 = 0; hoth = 0; cur_ticks = 0;
  endtask

  task automatic load_page();
    for (int i = 0; i < PB; i++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = AW'(i); wr_data = page[i];
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic run(input bit poke);
    int guard;
    model_clear();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (50) @(negedge clk);
      chk("R1", "ready low while busy", int'(wr_ready), 0);
      wr_valid = 1'b1; wr_addr = '0; wr_data = 8'h00; start = 1'b1;
      repeat (3) @(negedge clk);
      wr_valid = 1'b0; start = 1'b0;
    end
    guard = 0;
    while (!(done || fail) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  // predictions computed from the requirements
  task automatic predict_and_check(input string tag);
    int L, M, e10, bad, first_bad, exp_p, exp_done;
    bit newf [ML + 3];
    for (int n = 0; n < ML + 3; n++) newf[n] = 1'b0;
    M = 0;
    for (int b = 0; b < NB; b++) if (t0(b)) begin
      int m;
      m = (b == flaky_bit) ? need[b] + 2 : need[b];
      if (m > M) M = m;
    end
    if (stuck_bit >= 0) begin L = 1; exp_done = 0; end
    else if (M > ML) begin L = ML; exp_done = 0; end
    else begin L = M; exp_done = 1; end
    if (stuck_bit < 0)
      for (int b = 0; b < NB; b++) if (t0(b) && need[b] <= L) begin
        newf[need[b]] = 1'b1;
        if (b == flaky_bit) newf[need[b] + 2] = 1'b1;
      end
    e10 = 0;
    for (int n = 1; n <= ((L < EL) ? L : EL); n++) if (newf[n]) e10++;
    bad = 0; first_bad = -1;
    for (int b = 0; b < NB; b++) begin
      if (!t0(b)) exp_p = 0;
      else if (stuck_bit >= 0) exp_p = 1;
      else if (b == flaky_bit)
        exp_p = need[b] + 1 + int'(need[b] <= EL) + int'(need[b] + 2 <= EL);
      else if (need[b] > L) exp_p = L;
      else exp_p = need[b] + int'(need[b] <= EL);
      if (pulses[b] != exp_p) begin
        bad++;
        if (first_bad < 0) first_bad = b;
      end
    end
    $display("[TB] case %s: loops %0d", tag, L);
    chk("R8", "done", int'(done), exp_done);
    chk((stuck_bit >= 0) ? "R7" : "R9", "fail", int'(fail), 1 - exp_done);
    chk("R8", "loop_count", int'(loop_count), L);
    chk("R4", "short main pulses", h30, (L < EL) ? L : EL);
    chk("R4", "long main pulses", h200, (L > EL) ? L - EL : 0);
    chk("R5", "top-up pulses", e10, h10);
    chk("R3", "pulses of other width", hoth, 0);
    chk("R6", "cells with wrong pulse count", bad, 0);
    if (bad != 0) $display("  first mismatching cell %0d", first_bad);
  endtask

  task automatic set_needs(input int s);
    for (int b = 0; b < NB; b++) need[b] = t0(b) ? ((b * 5 + s * 3) % 9) + 1 : 1000;
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin need[b] = 1000; pulses[b] = 0; latched[b] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "busy", int'(busy), 0);
    chk("R10", "done", int'(done), 0);
    chk("R10", "fail", int'(fail), 0);
    chk("R10", "wr_ready", int'(wr_ready), 1);
    chk("R10", "strobes", int'(fl_pulse | fl_latch | fl_rd), 0);
    chk("R10", "loop_count", int'(loop_count), 0);

    // R8 all-ones page: no pulse at all
    for (int i = 0; i < PB; i++) page[i] = 8'hFF;
    set_needs(0);
    load_page();
    run(1'b0);
    predict_and_check("all ones");

    // R3..R6, R8 sweep of pages and cell strengths
    for (int s = 1; s <= 6; s++) begin
      for (int i = 0; i < PB; i++) page[i] = 8'((s * 37 + i * 91) & 255);
      set_needs(s);
      load_page();
      run(1'b0);
      predict_and_check($sformatf("sweep %0d", s));
    end

    // R6 a verified cell that later reads 1 is pulsed again
    for (int i = 0; i < PB; i++) page[i] = 8'h5A;
    set_needs(2);
    flaky_bit = 0; need[0] = 2; need[2] = 8;
    load_page();
    run(1'b0);
    predict_and_check("re-pulse");
    flaky_bit = -1;

    // R9 loop limit
    for (int i = 0; i < PB; i++) page[i] = 8'hC3;
    set_needs(4);
    need[2] = ML + 2;
    load_page();
    run(1'b0);
    predict_and_check("limit");

    // R7 target-1 cell reading 0
    for (int i = 0; i < PB; i++) page[i] = 8'hF0;
    set_needs(1);
    stuck_bit = 12;
    load_page();
    run(1'b0);
    predict_and_check("wrong zero");
    stuck_bit = -1;

    // R1/R2 writes and start while busy have no effect; page kept from before
    for (int i = 0; i < PB; i++) page[i] = 8'h96;
    set_needs(5);
    load_page();
    run(1'b1);
    predict_and_check("busy poke");
    run(1'b0);
    predict_and_check("page kept");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule